// File: doc/BRIEF.md
# Leveled Interrupt Priority Arbiter

This block chooses which pending interrupt the CPU takes next. Peripheral request lines are split into groups. Each group has a two-bit priority level that software writes. Level 0 switches the whole group off. A separate non-maskable request sits above every group. The CPU's current mask is a two-bit threshold, not a per-source bitmask. A maskable request is taken only when its group level is strictly above the threshold. The non-maskable request is taken whatever the threshold holds.

On every accept the block does three things. It pulses an acknowledge, reports the vector index and level of the winner, and raises the mask to the accepted level. It also pushes the previous mask onto a small saved-mask stack. A return pulse pops that stack and restores the earlier mask, so service routines can nest. Software may also overwrite the mask directly. Lowering it while a request flag is still set causes that request to be taken again.

Top module: `irq_level_arb`

## Requirements
- R1: After reset every group level is 0 and the mask is 00. No acknowledge follows, even with all requests and enables set.
- R2: A maskable request of level L is accepted only when L is greater than the mask value, read as a number. Mask 11 admits only the non-maskable request, 10 admits levels 3 and up, 01 admits levels 2 and up, and 00 admits levels 1 and up.
- R3: A source whose enable bit is clear, or whose group level is 0, is never accepted.
- R4: Among eligible maskable sources the highest level wins. Ties go to the lowest source number. The reported index is 0 for the non-maskable request and s+1 for source s. Source s belongs to group s / SRC_PER_GRP.
- R5: A rising edge on nmi_i is held pending until it is accepted, whatever the mask holds. On that acknowledge the index is 0, the level is 4 and the mask becomes 11.
- R6: Accepting a maskable level 1, 2 or 3 loads the mask with 01, 10 or 11 respectively.
- R7: Each accept pushes the previous mask onto a STK_DEPTH-deep stack (4 by default), and when the stack is full the oldest entry is discarded. A return pulse pops the stack into the mask. A return on an empty stack leaves the mask unchanged.
- R8: A mask write loads mask_wdata_i. A request that is still set is then accepted again if it is above the new mask.
- R9: Within one cycle a return pulse takes precedence over a mask write, and a mask write takes precedence over an accept. No acknowledge is given for a cycle that carries either one.
- R10: ack_o is high for exactly the one cycle after the clock edge at which the request was eligible. mask_o changes at that same edge, and idx_o and lvl_o hold their values until the next accept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | N_GRP*SRC_PER_GRP | Peripheral request flags |
| en_i | input | N_GRP*SRC_PER_GRP | Per-source enable bits |
| nmi_i | input | 1 | Non-maskable request, edge sensitive |
| ret_i | input | 1 | Return-from-service pulse |
| mask_we_i | input | 1 | Software mask write strobe |
| mask_wdata_i | input | 2 | Mask value to write |
| prio_we_i | input | 1 | Group level write strobe |
| prio_grp_i | input | clog2(N_GRP) | Group selected for the level write |
| prio_lvl_i | input | 2 | Level to write |
| ack_o | output | 1 | Accept strobe |
| idx_o | output | clog2(N_GRP*SRC_PER_GRP+1) | Vector index of the last winner |
| lvl_o | output | 3 | Level of the last winner (4 = non-maskable) |
| mask_o | output | 2 | Current CPU mask |

## Verification
Three things can arrive in the same cycle: a return pulse or a mask write, and an accept that would otherwise fire. The bench provokes this in two ways. It raises ret_i or mask_we_i while a request lies above the current mask, and it runs random cycles in which returns, mask writes, edges on the non-maskable input and request changes overlap freely. A bench model applies the fixed precedence of R9 to each such cycle. The cycle counts as correct only if no acknowledge appears, the mask takes the restored or written value, and the deferred request is accepted on the following edge.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  typedef logic [1:0] lvl2_t;
  localparam logic [2:0] LVL_NMI  = 3'd4;
  localparam lvl2_t      MASK_TOP = 2'b11;
endpackage

// File: rtl/irq_prio_regs.sv
module irq_prio_regs #(
  parameter int N_GRP = 4,
  localparam int GRP_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               we,
  input  logic [GRP_W-1:0]   sel,
  input  logic [1:0]         lvl,
  output logic [2*N_GRP-1:0] lvl_flat
);
  for (genvar g = 0; g < N_GRP; g++) begin : g_reg
    logic [1:0] r;
    always_ff @(posedge clk) begin
      if (rst)
        r <= 2'd0;
      else if (we && (sel == GRP_W'(g)))
        r <= lvl;
    end
    assign lvl_flat[2*g +: 2] = r;
  end
endmodule

// File: rtl/irq_select.sv
module irq_select #(
  parameter int N_GRP       = 4,
  parameter int SRC_PER_GRP = 4,
  localparam int N_SRC = N_GRP * SRC_PER_GRP,
  localparam int IDX_W = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0]   req,
  input  logic [N_SRC-1:0]   en,
  input  logic [2*N_GRP-1:0] grp_lvl,
  output logic [1:0]         best_lvl,
  output logic [IDX_W-1:0]   best_idx
);
  logic [1:0] eff [N_SRC];

  for (genvar s = 0; s < N_SRC; s++) begin : g_eff
    assign eff[s] = (req[s] && en[s]) ? grp_lvl[2*(s / SRC_PER_GRP) +: 2] : 2'd0;
  end

  // Scan from the top index down; ">=" lets a lower index take over a tie.
  always_comb begin
    best_lvl = 2'd0;
    best_idx = '0;
    for (int s = N_SRC - 1; s >= 0; s--) begin
      if (eff[s] != 2'd0 && eff[s] >= best_lvl) begin
        best_lvl = eff[s];
        best_idx = IDX_W'(s + 1);
      end
    end
  end
endmodule

// File: rtl/irq_mask_stack.sv
module irq_mask_stack #(
  parameter int DEPTH = 4,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       push,
  input  logic       pop,
  input  logic [1:0] din,
  output logic [1:0] top,
  output logic       empty
);
  logic [1:0]       ent [DEPTH];
  logic [CNT_W-1:0] cnt;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [1:0] from_below;
    logic [1:0] from_above;
    if (i == 0) begin : g_first
      assign from_below = din;
    end else begin : g_rest
      assign from_below = ent[i-1];
    end
    if (i == DEPTH - 1) begin : g_last
      assign from_above = 2'd0;
    end else begin : g_inner
      assign from_above = ent[i+1];
    end
    always_ff @(posedge clk) begin
      if (rst)
        ent[i] <= 2'd0;
      else if (push)
        ent[i] <= from_below;
      else if (pop)
        ent[i] <= from_above;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (push) begin
      if (cnt != CNT_W'(DEPTH))
        cnt <= cnt + 1'b1;
    end else if (pop && cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign top   = ent[0];
  assign empty = (cnt == '0);
endmodule

// File: rtl/irq_level_arb.sv
module irq_level_arb
  import irq_arb_pkg::*;
#(
  parameter int N_GRP       = 4,
  parameter int SRC_PER_GRP = 4,
  parameter int STK_DEPTH   = 4,
  localparam int N_SRC = N_GRP * SRC_PER_GRP,
  localparam int IDX_W = $clog2(N_SRC + 1),
  localparam int GRP_W = (N_GRP > 1) ? $clog2(N_GRP) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_SRC-1:0] req_i,
  input  logic [N_SRC-1:0] en_i,
  input  logic             nmi_i,
  input  logic             ret_i,
  input  logic             mask_we_i,
  input  logic [1:0]       mask_wdata_i,
  input  logic             prio_we_i,
  input  logic [GRP_W-1:0] prio_grp_i,
  input  logic [1:0]       prio_lvl_i,
  output logic             ack_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [2:0]       lvl_o,
  output logic [1:0]       mask_o
);
  logic [2*N_GRP-1:0] grp_lvl;
  lvl2_t              sel_lvl;
  logic [IDX_W-1:0]   sel_idx;
  lvl2_t              mask_q;
  lvl2_t              stk_top;
  logic               stk_empty;
  logic               nmi_q, nmi_pend;
  logic               nmi_live, blocked, take_nmi, take_irq, accept;

  irq_prio_regs #(.N_GRP(N_GRP)) prio_i (
    .clk(clk), .rst(rst), .we(prio_we_i), .sel(prio_grp_i),
    .lvl(prio_lvl_i), .lvl_flat(grp_lvl)
  );

  irq_select #(.N_GRP(N_GRP), .SRC_PER_GRP(SRC_PER_GRP)) sel_i (
    .req(req_i), .en(en_i), .grp_lvl(grp_lvl),
    .best_lvl(sel_lvl), .best_idx(sel_idx)
  );

  irq_mask_stack #(.DEPTH(STK_DEPTH)) stk_i (
    .clk(clk), .rst(rst), .push(accept), .pop(ret_i && !stk_empty),
    .din(mask_q), .top(stk_top), .empty(stk_empty)
  );

  assign nmi_live = nmi_pend | (nmi_i & ~nmi_q);
  assign blocked  = ret_i | mask_we_i;
  assign take_nmi = !blocked && nmi_live;
  assign take_irq = !blocked && !nmi_live && (sel_lvl > mask_q);
  assign accept   = take_nmi | take_irq;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= 2'b00;
      ack_o    <= 1'b0;
      idx_o    <= '0;
      lvl_o    <= 3'd0;
      nmi_q    <= 1'b0;
      nmi_pend <= 1'b0;
    end else begin
      ack_o    <= accept;
      nmi_q    <= nmi_i;
      nmi_pend <= take_nmi ? 1'b0 : nmi_live;
      if (ret_i) begin
        if (!stk_empty)
          mask_q <= stk_top;
      end else if (mask_we_i) begin
        mask_q <= mask_wdata_i;
      end else if (take_nmi) begin
        mask_q <= MASK_TOP;
        idx_o  <= '0;
        lvl_o  <= LVL_NMI;
      end else if (take_irq) begin
        mask_q <= sel_lvl;
        idx_o  <= sel_idx;
        lvl_o  <= {1'b0, sel_lvl};
      end
    end
  end

  assign mask_o = mask_q;
endmodule

// File: rtl/irq_level_arb_chk.sv
module irq_level_arb_chk #(
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             ret_i,
  input logic             mask_we_i,
  input logic             ack_o,
  input logic [IDX_W-1:0] idx_o,
  input logic [2:0]       lvl_o,
  input logic [1:0]       mask_o
);
  // R5
  nmi_mask_top_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && lvl_o == 3'd4) |-> (mask_o == 2'b11 && idx_o == '0));

  // R6
  irq_mask_load_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && lvl_o != 3'd4) |-> (mask_o == lvl_o[1:0]));

  // R2
  irq_above_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (ack_o && lvl_o != 3'd4) |-> (lvl_o[1:0] > $past(mask_o)));

  // R3
  no_zero_level_chk: assert property (@(posedge clk) disable iff (rst)
    ack_o |-> (lvl_o != 3'd0));

  // R9
  ret_blocks_ack_chk: assert property (@(posedge clk) disable iff (rst)
    ($past(ret_i) || $past(mask_we_i)) |-> !ack_o);
endmodule

bind irq_level_arb irq_level_arb_chk #(.IDX_W(IDX_W)) chk_i (
  .clk(clk), .rst(rst), .ret_i(ret_i), .mask_we_i(mask_we_i),
  .ack_o(ack_o), .idx_o(idx_o), .lvl_o(lvl_o), .mask_o(mask_o)
);

// File: tb/irq_level_arb_tb.sv
`timescale 1ns/1ps
module irq_level_arb_tb_top;
  localparam int NG = 4, SPG = 4, NS = NG * SPG, IW = $clog2(NS + 1);

  logic          clk = 1'b0, rst = 1'b1;
  logic [NS-1:0] req = '0, en = '0;
  logic          nmi = 1'b0, ret = 1'b0, mwe = 1'b0, pwe = 1'b0;
  logic [1:0]    mwd = '0, psel = '0, plvl = '0;
  logic          ack;
  logic [IW-1:0] idx;
  logic [2:0]    lvl;
  logic [1:0]    mask;

  int nchk = 0, nfail = 0;
  int m_prio [NG];
  int m_stk [4];
  int m_cnt, m_mask, m_nmiq, m_pend;
  int e_ack, e_idx, e_lvl;
  string e_tag;

  always #2.5 clk = ~clk;

  irq_level_arb dut_i (
    .clk(clk), .rst(rst), .req_i(req), .en_i(en), .nmi_i(nmi), .ret_i(ret),
    .mask_we_i(mwe), .mask_wdata_i(mwd), .prio_we_i(pwe), .prio_grp_i(psel),
    .prio_lvl_i(plvl), .ack_o(ack), .idx_o(idx), .lvl_o(lvl), .mask_o(mask)
  );

  task automatic chk(string tag, string what, int act, int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic m_push();
    for (int i = 3; i > 0; i--) m_stk[i] = m_stk[i-1];
    m_stk[0] = m_mask;
    if (m_cnt < 4) m_cnt++;
  endtask

  // Reference model of one clock edge, from the requirements.
  task automatic model_edge();
    int best, bidx, live;
    live = (m_pend != 0 || (nmi && m_nmiq == 0)) ? 1 : 0;
    best = 0; bidx = 0;
    for (int s = 0; s < NS; s++)
      if (req[s] && en[s] && m_prio[s / SPG] > best) begin
        best = m_prio[s / SPG]; bidx = s + 1;
      end
    e_ack = 0;
    e_tag = "R2";
    if ((ret || mwe) && (live != 0 || best > m_mask)) e_tag = "R9";
    if (ret) begin
      if (e_tag != "R9") e_tag = "R7";
      if (m_cnt > 0) begin
        m_mask = m_stk[0];
        for (int i = 0; i < 3; i++) m_stk[i] = m_stk[i+1];
        m_stk[3] = 0;
        m_cnt--;
      end
    end else if (mwe) begin
      if (e_tag != "R9") e_tag = "R8";
      m_mask = mwd;
    end else if (live != 0) begin
      m_push(); m_mask = 3; e_ack = 1; e_idx = 0; e_lvl = 4; e_tag = "R5";
    end else if (best > m_mask) begin
      m_push(); m_mask = best; e_ack = 1; e_idx = bidx; e_lvl = best; e_tag = "R4";
    end
    m_pend = (e_ack != 0 && e_idx == 0) ? 0 : live;
    m_nmiq = nmi;
    if (pwe) m_prio[psel] = plvl;
  endtask

  task automatic cyc();
    model_edge();
    @(posedge clk);
    #2;
    chk(e_tag, "ack", int'(ack), e_ack);
    chk(e_tag, "mask", int'(mask), m_mask);
    if (e_ack != 0) begin
      chk(e_tag, "idx", int'(idx), e_idx);
      chk(e_tag, "lvl", int'(lvl), e_lvl);
    end
  endtask

  task automatic setprio(int g, int l);
    pwe = 1'b1; psel = 2'(g); plvl = 2'(l);
    cyc();
    pwe = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    nfail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int g = 0; g < NG; g++) m_prio[g] = 0;
    for (int i = 0; i < 4; i++) m_stk[i] = 0;
    m_cnt = 0; m_mask = 0; m_nmiq = 0; m_pend = 0;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    chk("R1", "ack after reset", int'(ack), 0);
    chk("R1", "mask after reset", int'(mask), 0);

    // R1 / R3: all levels are zero, so nothing is taken
    req = '1; en = '1;
    cyc();
    chk("R1", "no ack at level 0", int'(ack), 0);
    req = '0;
    ret = 1'b1; cyc(); ret = 1'b0;
    chk("R7", "pop of empty stack", int'(mask), 0);

    // R4: tie at level 2 between sources 2 and 5
    setprio(0, 2);
    setprio(1, 2);
    req = NS'((1 << 2) | (1 << 5)); en = '1;
    cyc();
    chk("R4", "tie to lowest index", int'(idx), 3);
    chk("R6", "mask after level 2", int'(mask), 2);
    cyc();
    chk("R2", "same level blocked", int'(ack), 0);

    // R3: disabled source with level 3
    setprio(3, 3);
    req = req | NS'(1 << 13); en = ~NS'(1 << 13);
    cyc();
    chk("R3", "disabled source", int'(ack), 0);
    en = '1;
    cyc();
    chk("R2", "level 3 over mask 10", int'(idx), 14);
    chk("R6", "mask after level 3", int'(mask), 3);

    // R5: NMI over mask 11
    nmi = 1'b1; cyc();
    chk("R5", "nmi level", int'(lvl), 4);
    chk("R5", "nmi mask", int'(mask), 3);
    nmi = 1'b0; req = '0;
    cyc();
    chk("R10", "ack is one pulse", int'(ack), 0);
    chk("R10", "lvl held", int'(lvl), 4);

    // R7: unwind
    ret = 1'b1;
    cyc(); chk("R7", "pop 1", int'(mask), 3);
    cyc(); chk("R7", "pop 2", int'(mask), 2);
    cyc(); chk("R7", "pop 3", int'(mask), 0);
    cyc(); chk("R7", "pop empty", int'(mask), 0);
    ret = 1'b0;

    // R9: return and request in the same cycle
    req = NS'(1 << 2); ret = 1'b1;
    cyc(); chk("R9", "ret blocks accept", int'(ack), 0);
    ret = 1'b0;
    cyc(); chk("R9", "deferred accept", int'(ack), 1);

    // R8: lowering the mask re-takes a live request
    mwe = 1'b1; mwd = 2'b00;
    cyc(); chk("R8", "write wins", int'(mask), 0);
    chk("R9", "write blocks accept", int'(ack), 0);
    mwe = 1'b0;
    cyc(); chk("R8", "re-accept", int'(idx), 3);

    // R7: overflow of the saved-mask stack
    req = '0; ret = 1'b1;
    repeat (3) cyc();
    ret = 1'b0;
    setprio(0, 1);
    req = NS'(1 << 0); cyc();
    req = req | NS'(1 << 5); cyc();
    req = req | NS'(1 << 13); cyc();
    nmi = 1'b1; cyc();
    nmi = 1'b0; cyc();
    nmi = 1'b1; cyc();
    chk("R5", "second nmi", int'(ack), 1);
    nmi = 1'b0; req = '0;
    cyc();
    ret = 1'b1;
    cyc(); chk("R7", "ovf pop 1", int'(mask), 3);
    cyc(); chk("R7", "ovf pop 2", int'(mask), 3);
    cyc(); chk("R7", "ovf pop 3", int'(mask), 2);
    cyc(); chk("R7", "ovf pop 4", int'(mask), 1);
    cyc(); chk("R7", "oldest dropped", int'(mask), 1);
    ret = 1'b0;

    // Random phase
    void'($urandom(32'd20240611));
    for (int n = 0; n < 4000; n++) begin
      req  = NS'($urandom);
      en   = NS'($urandom);
      ret  = ($urandom_range(0, 9) == 0);
      mwe  = ($urandom_range(0, 11) == 0);
      mwd  = 2'($urandom);
      pwe  = ($urandom_range(0, 9) == 0);
      psel = 2'($urandom);
      plvl = 2'($urandom);
      if ($urandom_range(0, 7) == 0) nmi = ~nmi;
      cyc();
    end
    finish_run();
  end
endmodule